// File: doc/BRIEF.md
# Load and Store Buffer Unit

This unit sits between the issue stage of a tag-based out-of-order core and a single-ported data memory. Issue hands it loads and stores as a base and an offset. Each entry forms its effective address one cycle after it is allocated. A load entry reads memory and keeps the returned word. It then asks for the common result bus, and when granted it broadcasts the word under a tag that belongs to that entry.

A store entry either gets its data value at allocation or records the tag of the instruction that will produce it. In the second case it watches the result bus for that tag. A store writes memory only once its address and its data are both present.

All memory traffic leaves in allocation order through one port, with one request outstanding at a time. A load that follows a store to the same address therefore reads the stored value. When no entry of the requested kind is free, the allocation is refused.

Top module: `lsq_unit`

## Requirements
- R1: After reset no memory request and no result-bus request is raised, and `alloc_ready` is high for both kinds.
- R2: The address sent to memory is the sum of the entry's base and offset, truncated to AW bits, so that 0xFFFF + 0x0007 gives 0x0006.
- R3: Memory requests leave in the order their entries were allocated. A ready entry waits behind an older entry that cannot issue yet.
- R4: At most one memory request is outstanding. `mem_req` is a one-cycle pulse, and the next one comes only after `mem_resp` has arrived.
- R5: A store raises a write (`mem_we` = 1) only when both its address and its data are present. A store still waiting for its data tag writes nothing.
- R6: A waiting store takes `res_data` when `res_valid` is high and `res_tag` equals its recorded producer tag. A broadcast with any other tag leaves it waiting.
- R7: Result-bus broadcasts never reach load entries. A load broadcasts the word memory returned, even when its own tag appears on `res_tag` while it waits.
- R8: A load with data raises `bus_req`. It holds `bus_req`, `bus_tag` and `bus_data` steady until a cycle with `bus_grant`, then drops the request and frees the entry.
- R9: A load allocated after a store to the same address receives the value that store wrote.
- R10: `alloc_ready` is low when no entry of the kind chosen by `alloc_is_store` is free. An allocation offered then is ignored and produces no memory or bus traffic.
- R11: A new load takes the lowest free load entry. Its tag, shown on `alloc_tag`, is LTAG0 plus the entry index (8 and 9 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Issue offers an entry this cycle |
| alloc_is_store | input | 1 | 1 = store entry, 0 = load entry |
| alloc_base | input | AW | Base address component |
| alloc_off | input | AW | Offset address component |
| alloc_data_rdy | input | 1 | Store data value is already known |
| alloc_data | input | DW | Store data value when known |
| alloc_data_tag | input | TW | Producer tag of the store data when not known |
| alloc_ready | output | 1 | An entry of the requested kind is free |
| alloc_tag | output | TW | Tag the offered load will carry |
| res_valid | input | 1 | Result-bus broadcast valid |
| res_tag | input | TW | Tag of the broadcast result |
| res_data | input | DW | Broadcast result value |
| bus_req | output | 1 | A load asks for the result bus |
| bus_tag | output | TW | Tag of the requesting load |
| bus_data | output | DW | Loaded word of the requesting load |
| bus_grant | input | 1 | Result bus granted this cycle |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_resp | input | 1 | Memory finished the outstanding request |
| mem_rdata | input | DW | Read data, valid with mem_resp |

## Verification
The checks on the memory port assume that `mem_resp` arrives only while a request is outstanding, and only for one cycle per request. The bench memory model answers each request exactly once, after a latency that rotates through one, two and three cycles. The bus checks assume that `bus_grant` is raised only while `bus_req` is high. The bench derives the grant from `bus_req` in the same half cycle, and it can withhold the grant for long stretches to test holding. Broadcasts on `res_tag` use producer tags outside the load tag range, except where a load's own tag is sent on purpose to show that loads ignore it.

// File: rtl/lsq_unit.sv
module lsq_unit #(
  parameter int NLD   = 2,
  parameter int NST   = 2,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TW    = 4,
  parameter int LTAG0 = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          alloc_is_store,
  input  logic [AW-1:0] alloc_base,
  input  logic [AW-1:0] alloc_off,
  input  logic          alloc_data_rdy,
  input  logic [DW-1:0] alloc_data,
  input  logic [TW-1:0] alloc_data_tag,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_data,
  output logic          bus_req,
  output logic [TW-1:0] bus_tag,
  output logic [DW-1:0] bus_data,
  input  logic          bus_grant,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_resp,
  input  logic [DW-1:0] mem_rdata
);
  localparam int LIW = (NLD > 1) ? $clog2(NLD) : 1;
  localparam int SIW = (NST > 1) ? $clog2(NST) : 1;
  localparam int IW  = (LIW > SIW) ? LIW : SIW;
  localparam int QD  = NLD + NST;
  localparam int QW  = $clog2(QD);
  localparam int CW  = $clog2(QD + 1);

  logic [NLD-1:0] l_vld, l_aok, l_done;
  logic [AW-1:0]  l_base [NLD];
  logic [AW-1:0]  l_off  [NLD];
  logic [AW-1:0]  l_ea   [NLD];
  logic [DW-1:0]  l_data [NLD];

  logic [NST-1:0] s_vld, s_aok, s_dok;
  logic [AW-1:0]  s_base [NST];
  logic [AW-1:0]  s_off  [NST];
  logic [AW-1:0]  s_ea   [NST];
  logic [DW-1:0]  s_data [NST];
  logic [TW-1:0]  s_dtag [NST];

  logic           q_st  [QD];
  logic [IW-1:0]  q_idx [QD];
  logic [QW-1:0]  q_head, q_tail;
  logic [CW-1:0]  q_cnt;

  logic           busy, fl_st, bhold;
  logic [IW-1:0]  fl_idx;
  logic [LIW-1:0] bcur;

  logic           l_free_any, s_free_any, ld_done_any;
  logic [LIW-1:0] l_free_i, ld_done_i;
  logic [SIW-1:0] s_free_i;

  always_comb begin
    l_free_any = 1'b0; l_free_i = '0;
    ld_done_any = 1'b0; ld_done_i = '0;
    for (int i = NLD - 1; i >= 0; i--) begin
      if (!l_vld[i]) begin l_free_any = 1'b1; l_free_i = LIW'(i); end
      if (l_vld[i] && l_done[i]) begin ld_done_any = 1'b1; ld_done_i = LIW'(i); end
    end
    s_free_any = 1'b0; s_free_i = '0;
    for (int i = NST - 1; i >= 0; i--)
      if (!s_vld[i]) begin s_free_any = 1'b1; s_free_i = SIW'(i); end
  end

  assign alloc_ready = alloc_is_store ? s_free_any : l_free_any;
  assign alloc_tag   = TW'(LTAG0) + TW'(l_free_i);
  wire   do_alloc    = alloc_valid && alloc_ready;

  wire           hd_st  = q_st[q_head];
  wire [IW-1:0]  hd_idx = q_idx[q_head];
  wire [LIW-1:0] hl     = hd_idx[LIW-1:0];
  wire [SIW-1:0] hs     = hd_idx[SIW-1:0];
  wire           hd_ok  = (q_cnt != '0) && (hd_st ? (s_aok[hs] && s_dok[hs]) : l_aok[hl]);

  assign mem_req   = hd_ok && !busy;
  assign mem_we    = hd_st;
  assign mem_addr  = hd_st ? s_ea[hs] : l_ea[hl];
  assign mem_wdata = s_data[hs];

  assign bus_req  = bhold;
  assign bus_tag  = TW'(LTAG0) + TW'(bcur);
  assign bus_data = l_data[bcur];

  wire push = do_alloc;
  wire pop  = mem_req;
  wire alloc_snoop = res_valid && (res_tag == alloc_data_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_vld <= '0; l_aok <= '0; l_done <= '0;
      s_vld <= '0; s_aok <= '0; s_dok <= '0;
      q_head <= '0; q_tail <= '0; q_cnt <= '0;
      busy <= 1'b0; fl_st <= 1'b0; fl_idx <= '0;
      bhold <= 1'b0; bcur <= '0;
      for (int i = 0; i < NLD; i++) begin
        l_base[i] <= '0; l_off[i] <= '0; l_ea[i] <= '0; l_data[i] <= '0;
      end
      for (int i = 0; i < NST; i++) begin
        s_base[i] <= '0; s_off[i] <= '0; s_ea[i] <= '0; s_data[i] <= '0; s_dtag[i] <= '0;
      end
      for (int i = 0; i < QD; i++) begin q_st[i] <= 1'b0; q_idx[i] <= '0; end
    end else begin
      for (int i = 0; i < NLD; i++)
        if (l_vld[i] && !l_aok[i]) begin l_ea[i] <= l_base[i] + l_off[i]; l_aok[i] <= 1'b1; end
      for (int i = 0; i < NST; i++) begin
        if (s_vld[i] && !s_aok[i]) begin s_ea[i] <= s_base[i] + s_off[i]; s_aok[i] <= 1'b1; end
        if (s_vld[i] && !s_dok[i] && res_valid && res_tag == s_dtag[i]) begin
          s_data[i] <= res_data; s_dok[i] <= 1'b1;
        end
      end

      if (do_alloc) begin
        if (alloc_is_store) begin
          s_vld[s_free_i]  <= 1'b1; s_aok[s_free_i] <= 1'b0;
          s_base[s_free_i] <= alloc_base; s_off[s_free_i] <= alloc_off;
          s_dtag[s_free_i] <= alloc_data_tag;
          s_dok[s_free_i]  <= alloc_data_rdy || alloc_snoop;
          s_data[s_free_i] <= alloc_data_rdy ? alloc_data : res_data;
        end else begin
          l_vld[l_free_i]  <= 1'b1; l_aok[l_free_i] <= 1'b0; l_done[l_free_i] <= 1'b0;
          l_base[l_free_i] <= alloc_base; l_off[l_free_i] <= alloc_off;
        end
        q_st[q_tail]  <= alloc_is_store;
        q_idx[q_tail] <= alloc_is_store ? IW'(s_free_i) : IW'(l_free_i);
        q_tail <= (q_tail == QW'(QD - 1)) ? '0 : q_tail + 1'b1;
      end

      if (pop) begin
        q_head <= (q_head == QW'(QD - 1)) ? '0 : q_head + 1'b1;
        busy <= 1'b1; fl_st <= hd_st; fl_idx <= hd_idx;
      end else if (busy && mem_resp) begin
        busy <= 1'b0;
        if (fl_st) s_vld[fl_idx[SIW-1:0]] <= 1'b0;
        else begin l_data[fl_idx[LIW-1:0]] <= mem_rdata; l_done[fl_idx[LIW-1:0]] <= 1'b1; end
      end
      q_cnt <= q_cnt + CW'(push) - CW'(pop);

      if (bhold && bus_grant) begin
        bhold <= 1'b0; l_vld[bcur] <= 1'b0; l_done[bcur] <= 1'b0;
      end else if (!bhold && ld_done_any) begin
        bhold <= 1'b1; bcur <= ld_done_i;
      end
    end
  end
endmodule

// File: rtl/lsq_unit_chk.sv
module lsq_unit_chk #(
  parameter int TW = 4,
  parameter int DW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_resp,
  input logic          bus_req,
  input logic          bus_grant,
  input logic [TW-1:0] bus_tag,
  input logic [DW-1:0] bus_data
);
  logic outstanding;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req) outstanding <= 1'b1;
    else if (mem_resp) outstanding <= 1'b0;
  end

  AST_SINGLE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !outstanding); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R4
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_grant |=> bus_req && $stable(bus_tag) && $stable(bus_data)); // R8
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) bus_req && bus_grant |=> !bus_req); // R8
endmodule

bind lsq_unit lsq_unit_chk #(.TW(TW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_resp(mem_resp),
  .bus_req(bus_req), .bus_grant(bus_grant), .bus_tag(bus_tag), .bus_data(bus_data)
);

// File: tb/lsq_unit_test.sv
module lsq_unit_test;
  localparam int AW = 16, DW = 32, TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          alloc_valid = 0, alloc_is_store = 0, alloc_data_rdy = 0;
  logic [AW-1:0] alloc_base = '0, alloc_off = '0;
  logic [DW-1:0] alloc_data = '0;
  logic [TW-1:0] alloc_data_tag = '0;
  logic          alloc_ready;
  logic [TW-1:0] alloc_tag;
  logic          res_valid = 0;
  logic [TW-1:0] res_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic          bus_req, bus_grant = 0;
  logic [TW-1:0] bus_tag;
  logic [DW-1:0] bus_data;
  logic          mem_req, mem_we, mem_resp = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;

  lsq_unit uut (.*);

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mem [0:15];
  int m_addr [0:63]; int m_we [0:63]; logic [DW-1:0] m_data [0:63];
  int n_mem = 0, overlap = 0;
  int b_tag [0:63]; logic [DW-1:0] b_data [0:63];
  int n_bus = 0;
  bit grant_en = 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model, one response per request, rotating latency
  initial begin
    bit pend = 0; int cnt = 0; int pa = 0; bit pw = 0; logic [DW-1:0] pd = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (mem_resp) mem_resp = 0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          mem_rdata = pw ? '0 : mem[pa];
          if (pw) mem[pa] = pd;
          mem_resp = 1; pend = 0;
        end
      end
      if (rst_n && mem_req === 1'b1) begin
        if (pend || mem_resp) overlap++;
        m_addr[n_mem] = int'(mem_addr); m_we[n_mem] = int'(mem_we); m_data[n_mem] = mem_wdata;
        pa = int'(mem_addr[3:0]); pw = mem_we; pd = mem_wdata;
        n_mem++; pend = 1; cnt = 1 + (n_mem % 3);
      end
    end
  end

  // result-bus arbiter model
  initial begin
    forever begin
      @(negedge clk);
      bus_grant = grant_en && rst_n && (bus_req === 1'b1);
      if (bus_grant) begin b_tag[n_bus] = int'(bus_tag); b_data[n_bus] = bus_data; n_bus++; end
    end
  end

  task automatic alloc(bit st, logic [AW-1:0] base, logic [AW-1:0] off, bit rdy,
                       logic [DW-1:0] d, logic [TW-1:0] dt, output int tg, output bit ok);
    @(negedge clk);
    alloc_valid = 1; alloc_is_store = st; alloc_base = base; alloc_off = off;
    alloc_data_rdy = rdy; alloc_data = d; alloc_data_tag = dt;
    #1 ok = alloc_ready; tg = int'(alloc_tag);
    @(negedge clk);
    alloc_valid = 0; alloc_data_rdy = 0;
  endtask

  task automatic bcast(logic [TW-1:0] t, logic [DW-1:0] d);
    @(negedge clk); res_valid = 1; res_tag = t; res_data = d;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic wait_cnt(ref int c, input int target, input string req);
    int k = 0;
    while (c < target && k < 300) begin @(negedge clk); k++; end
    chk(c >= target, req, "event did not occur", c, target);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    alloc_is_store = 0; #1;
    chk(alloc_ready == 1, "R1", "load alloc_ready", alloc_ready, 1);
    alloc_is_store = 1; #1;
    chk(alloc_ready == 1, "R1", "store alloc_ready", alloc_ready, 1);
    alloc_is_store = 0;
    chk(mem_req == 0, "R1", "mem_req", mem_req, 0);
    chk(bus_req == 0, "R1", "bus_req", bus_req, 0);
  endtask

  task automatic t_load_basic;
    int tg; bit ok; int m0, b0;
    mem[5] = 32'h0000A5A5; mem[6] = 32'h00006666;
    m0 = n_mem; b0 = n_bus;
    alloc(0, 16'd3, 16'd2, 0, '0, '0, tg, ok);
    chk(ok && tg == 8, "R11", "first load tag", tg, 8);
    wait_cnt(n_bus, b0 + 1, "R8");
    chk(m_addr[m0] == 5 && m_we[m0] == 0, "R2", "load address", m_addr[m0], 5);
    chk(b_tag[b0] == 8, "R8", "bus tag", b_tag[b0], 8);
    chk(b_data[b0] == 32'hA5A5, "R8", "bus data", b_data[b0], 32'hA5A5);
    alloc(0, 16'hFFFF, 16'h0007, 0, '0, '0, tg, ok);
    wait_cnt(n_bus, b0 + 2, "R2");
    chk(m_addr[m0+1] == 6, "R2", "wrapped address", m_addr[m0+1], 6);
    chk(b_data[b0+1] == 32'h6666, "R2", "wrapped load data", b_data[b0+1], 32'h6666);
    chk(tg == 8, "R11", "freed entry reused", tg, 8);
  endtask

  task automatic t_store_ready;
    int tg; bit ok; int m0;
    m0 = n_mem;
    alloc(1, 16'd1, 16'd1, 1, 32'h1234, '0, tg, ok);
    alloc(1, 16'd10, 16'd1, 1, 32'h5678, '0, tg, ok);
    wait_cnt(n_mem, m0 + 2, "R5");
    idle(5);
    chk(m_we[m0] == 1 && m_addr[m0] == 2, "R5", "store write addr", m_addr[m0], 2);
    chk(m_addr[m0+1] == 11, "R3", "second store in order", m_addr[m0+1], 11);
    chk(mem[2] == 32'h1234, "R5", "memory after store", mem[2], 32'h1234);
    chk(mem[11] == 32'h5678, "R5", "memory after second store", mem[11], 32'h5678);
  endtask

  task automatic t_store_wait;
    int tg; bit ok; int m0, b0;
    m0 = n_mem; b0 = n_bus;
    alloc(1, 16'd8, 16'd0, 0, '0, 4'd3, tg, ok);
    alloc(0, 16'd4, 16'd4, 0, '0, '0, tg, ok);
    idle(10);
    chk(n_mem == m0, "R5", "store without data wrote", n_mem - m0, 0);
    chk(n_bus == b0, "R3", "load passed waiting store", n_bus - b0, 0);
    bcast(4'd5, 32'h0BAD);
    idle(6);
    chk(n_mem == m0, "R6", "wrong tag released store", n_mem - m0, 0);
    bcast(4'd3, 32'hBEEF);
    wait_cnt(n_bus, b0 + 1, "R6");
    chk(m_we[m0] == 1 && m_data[m0] == 32'hBEEF, "R6", "snooped store data", m_data[m0], 32'hBEEF);
    chk(m_we[m0+1] == 0, "R3", "load after store", m_we[m0+1], 0);
    chk(b_data[b0] == 32'hBEEF, "R9", "load sees stored value", b_data[b0], 32'hBEEF);
  endtask

  task automatic t_load_ignores;
    int tg; bit ok; int b0;
    mem[9] = 32'h7777; b0 = n_bus;
    alloc(0, 16'd9, 16'd0, 0, '0, '0, tg, ok);
    bcast(TW'(tg), 32'hDEAD);
    wait_cnt(n_bus, b0 + 1, "R7");
    chk(b_data[b0] == 32'h7777, "R7", "load data from memory", b_data[b0], 32'h7777);
  endtask

  task automatic t_hold_stall;
    int tg0, tg1, tg2; bit ok0, ok1, ok2, oks; int m0, b0; logic [DW-1:0] d0;
    mem[4] = 32'h44; mem[13] = 32'h1313; mem[12] = 32'hCC;
    m0 = n_mem; b0 = n_bus; grant_en = 0;
    alloc(0, 16'd4, 16'd0, 0, '0, '0, tg0, ok0);
    alloc(0, 16'd13, 16'd0, 0, '0, '0, tg1, ok1);
    chk(tg1 == 9, "R11", "second load tag", tg1, 9);
    idle(20);
    chk(bus_req == 1, "R8", "bus_req held", bus_req, 1);
    chk(bus_data == 32'h44 && bus_tag == 8, "R8", "held data", bus_data, 32'h44);
    alloc(0, 16'd12, 16'd0, 0, '0, '0, tg2, ok2);
    chk(ok2 == 0, "R10", "load ready while full", ok2, 0);
    @(negedge clk); alloc_is_store = 1; #1 oks = alloc_ready; alloc_is_store = 0;
    chk(oks == 1, "R10", "store ready while loads full", oks, 1);
    grant_en = 1;
    wait_cnt(n_bus, b0 + 2, "R8");
    idle(15);
    chk(b_tag[b0] == 8 && b_tag[b0+1] == 9, "R8", "grant order tags", b_tag[b0+1], 9);
    d0 = b_data[b0+1];
    chk(d0 == 32'h1313, "R8", "second held data", d0, 32'h1313);
    chk(n_mem - m0 == 2, "R10", "refused alloc made traffic", n_mem - m0, 2);
    chk(n_bus - b0 == 2, "R10", "refused alloc made broadcast", n_bus - b0, 2);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_load_basic;
    t_store_ready;
    t_store_wait;
    t_load_ignores;
    t_hold_stall;
    chk(overlap == 0, "R4", "overlapping memory requests", overlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule